// File: doc/BRIEF.md
# Phase-Synchronized Up-Down PWM Timebase

This block is the counting core of a centre-aligned PWM channel. A counter climbs from zero to an active period value and falls back to zero, over and over. On the way it raises one-clock strobes when it reaches zero, when it reaches the period, and when it passes each of two compare values, with separate strobes for the rising and falling halves. Action logic placed downstream uses these strobes to set and clear the PWM pins.

Several timebases can be run in lockstep. A master timer pulses its sync output each time it reaches zero. A slave timer with phase loading enabled jumps to a programmed phase offset on every sync pulse and then counts in a programmed direction. The phase offset and the direction are written straight into live state, so a sync in the same cycle as the write already uses the new value. The period and the compare values are different. Writes to them land in shadow registers and reach the active copies only at a counter-zero cycle. Shadow loading can be gated so that it happens only at the zero that follows an explicit arm command. That lets a full set of new values switch over together.

Registers are written through a simple port of address, data and enable. The address map is: 0 control, 1 phase, 2 period, 3 compare A, 4 compare B, 5 command.

Top module: `ptb_timebase`

## Requirements
- R1: After reset the count is 0 with the direction output high (up). Control (address 0), phase (address 1) and arm state are 0. The active and shadow period are RST_PRD, compare A is RST_CMPA and compare B is RST_CMPB.
- R2: With no sync, the count steps by one each clock. It rises 0,1,…,P and then falls P−1,…,0, where P is the active period. The direction output shows the direction of the step that produced the current value. It turns low on the step away from P and high on the step away from 0.
- R3: If control bit 0 (phase enable) is set and a sync occurs, the next count equals the phase value. The next direction then equals control bit 1 (1 = up). While control bit 0 is clear, syncs do not alter the count.
- R4: A write to the control or phase register is used by a sync that occurs in that same cycle.
- R5: Writes to the period (address 2), compare A (address 3) and compare B (address 4) go to shadow registers. When control bit 3 is clear, the shadows are copied to the active values in every cycle where the count is 0. The new values take effect from the following cycle.
- R6: When control bit 3 is set, a copy happens only at a zero cycle while armed. Writing 1 to bit 0 of the command register (address 5) arms the load. The arm clears itself when that load happens.
- R7: The sync output is high in every cycle where the count is 0 and control bit 2 is set. It is also high for exactly one cycle on the clock after bit 1 of the command register is written with 1.
- R8: That software sync pulse also acts as a local sync in the cycle it is high. It reloads the counter when phase loading is enabled.
- R9: Each strobe is high only in a cycle where the count equals its value: zero; the active period; compare A or B with the direction high (up strobes) or low (down strobes).
- R10: When a sync and a zero-cycle shadow copy coincide, the counter takes the phase value and the copy still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| sync_in | input | 1 | External sync pulse |
| sync_out | output | 1 | Sync pulse to other timers |
| count | output | CNT_W | Current counter value |
| count_up | output | 1 | Direction of the step that produced the count |
| ev_zero | output | 1 | Count equals zero |
| ev_prd | output | 1 | Count equals active period |
| ev_cmpa_up | output | 1 | Compare A match while rising |
| ev_cmpa_dn | output | 1 | Compare A match while falling |
| ev_cmpb_up | output | 1 | Compare B match while rising |
| ev_cmpb_dn | output | 1 | Compare B match while falling |

## Verification
Some rules are checked on every cycle by the assertions. Each unsynced step moves the count by exactly one. The direction flips at the period and at zero. Every reload lands on the phase and direction seen in the cycle before. The active period stays frozen except in a load cycle. A gated load never fires while unarmed and always disarms. A zero with sync-out enabled always drives the sync output. Other behaviour can only be shown by the bench's scenarios. These are the exact strobe positions across a whole triangle, and that a period written mid-cycle is ignored until the next zero. They also include the same-cycle use of a freshly written phase and direction, the single-pulse nature of the software sync, and the result of a sync landing on the very cycle of a shadow copy.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_PHASE = 3'd1,
        REG_PRD   = 3'd2,
        REG_CMPA  = 3'd3,
        REG_CMPB  = 3'd4,
        REG_CMD   = 3'd5
    } reg_addr_e;

    // Control word, bit 0 is phase_en
    typedef struct packed {
        logic gated_load;
        logic syncout_zero;
        logic dir_up;
        logic phase_en;
    } ctrl_t;

    localparam int CTRL_W     = $bits(ctrl_t);
    localparam int CMD_ARM    = 0;
    localparam int CMD_SWSYNC = 1;
    localparam int N_CMP      = 2;

    function automatic logic hit(input logic en, input logic [2:0] addr,
                                 input reg_addr_e target);
        return en && (addr == target);
    endfunction

endpackage

// File: rtl/ptb_regs.sv
module ptb_regs
    import ptb_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int RST_PRD  = 10,
    parameter int RST_CMPA = 4,
    parameter int RST_CMPB = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [2:0]                  wr_addr,
    input  logic [CNT_W-1:0]            wr_data,
    input  logic                        at_zero,
    output ctrl_t                       ctrl_q,
    output ctrl_t                       ctrl_eff,
    output logic [CNT_W-1:0]            phase_eff,
    output logic [CNT_W-1:0]            prd_act,
    output logic [N_CMP-1:0][CNT_W-1:0] cmp_act,
    output logic                        sw_sync,
    output logic                        armed,
    output logic                        ld_go
);
    localparam logic [CNT_W-1:0] PRD_INIT = CNT_W'(RST_PRD);

    logic [CNT_W-1:0] phase_q;
    logic [CNT_W-1:0] prd_sh;
    logic             wr_cmd;

    // Control and phase are live: a same-cycle write bypasses the flop
    assign ctrl_eff  = hit(wr_en, wr_addr, REG_CTRL) ? ctrl_t'(wr_data[CTRL_W-1:0]) : ctrl_q;
    assign phase_eff = hit(wr_en, wr_addr, REG_PHASE) ? wr_data : phase_q;
    assign wr_cmd    = hit(wr_en, wr_addr, REG_CMD);
    assign ld_go     = at_zero && (!ctrl_q.gated_load || armed);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            phase_q <= '0;
            sw_sync <= 1'b0;
            armed   <= 1'b0;
            prd_sh  <= PRD_INIT;
            prd_act <= PRD_INIT;
        end else begin
            ctrl_q  <= ctrl_eff;
            phase_q <= phase_eff;
            sw_sync <= wr_cmd && wr_data[CMD_SWSYNC];
            if (ld_go && ctrl_q.gated_load)
                armed <= 1'b0;
            else if (wr_cmd && wr_data[CMD_ARM])
                armed <= 1'b1;
            if (hit(wr_en, wr_addr, REG_PRD))
                prd_sh <= wr_data;
            if (ld_go)
                prd_act <= prd_sh;
        end
    end

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        localparam logic [CNT_W-1:0] CMP_INIT = CNT_W'((g == 0) ? RST_CMPA : RST_CMPB);
        localparam reg_addr_e        CMP_ADDR = (g == 0) ? REG_CMPA : REG_CMPB;
        logic [CNT_W-1:0] sh_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q       <= CMP_INIT;
                cmp_act[g] <= CMP_INIT;
            end else begin
                if (hit(wr_en, wr_addr, CMP_ADDR))
                    sh_q <= wr_data;
                if (ld_go)
                    cmp_act[g] <= sh_q;
            end
        end
    end

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [CNT_W-1:0] phase,
    input  logic             dir_in,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt,
    output logic             up
);
    logic [CNT_W-1:0] cnt_d;
    logic             up_d;

    always_comb begin
        cnt_d = cnt;
        up_d  = up;
        if (reload) begin
            cnt_d = phase;
            up_d  = dir_in;
        end else if (up) begin
            if (cnt >= prd) begin
                cnt_d = (prd == '0) ? '0 : cnt - 1'b1;
                up_d  = 1'b0;
            end else begin
                cnt_d = cnt + 1'b1;
            end
        end else begin
            if (cnt == '0) begin
                cnt_d = (prd == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
                up_d  = 1'b1;
            end else begin
                cnt_d = cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            up  <= 1'b1;
        end else begin
            cnt <= cnt_d;
            up  <= up_d;
        end
    end

endmodule

// File: rtl/ptb_events.sv
module ptb_events
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0]            cnt,
    input  logic                        up,
    input  logic [CNT_W-1:0]            prd,
    input  logic [N_CMP-1:0][CNT_W-1:0] cmp,
    output logic                        ev_zero,
    output logic                        ev_prd,
    output logic [N_CMP-1:0]            ev_up,
    output logic [N_CMP-1:0]            ev_dn
);
    assign ev_zero = (cnt == '0);
    assign ev_prd  = (cnt == prd);

    for (genvar g = 0; g < N_CMP; g++) begin : g_match
        logic eq;
        assign eq       = (cnt == cmp[g]);
        assign ev_up[g] = eq && up;
        assign ev_dn[g] = eq && !up;
    end

endmodule

// File: rtl/ptb_timebase.sv
module ptb_timebase
    import ptb_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int RST_PRD  = 10,
    parameter int RST_CMPA = 4,
    parameter int RST_CMPB = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             sync_in,
    output logic             sync_out,
    output logic [CNT_W-1:0] count,
    output logic             count_up,
    output logic             ev_zero,
    output logic             ev_prd,
    output logic             ev_cmpa_up,
    output logic             ev_cmpa_dn,
    output logic             ev_cmpb_up,
    output logic             ev_cmpb_dn
);
    ctrl_t                       ctrl_q;
    ctrl_t                       ctrl_eff;
    logic [CNT_W-1:0]            phase_eff;
    logic [CNT_W-1:0]            prd_act;
    logic [N_CMP-1:0][CNT_W-1:0] cmp_act;
    logic                        sw_sync;
    logic                        armed;
    logic                        ld_go;
    logic                        reload;
    logic                        dir_eff;
    logic                        gated;
    logic                        so_en;
    logic [N_CMP-1:0]            ev_up;
    logic [N_CMP-1:0]            ev_dn;

    ptb_regs #(
        .CNT_W(CNT_W), .RST_PRD(RST_PRD), .RST_CMPA(RST_CMPA), .RST_CMPB(RST_CMPB)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .at_zero(ev_zero), .ctrl_q(ctrl_q), .ctrl_eff(ctrl_eff), .phase_eff(phase_eff),
        .prd_act(prd_act), .cmp_act(cmp_act), .sw_sync(sw_sync), .armed(armed),
        .ld_go(ld_go)
    );

    assign dir_eff = ctrl_eff.dir_up;
    assign gated   = ctrl_q.gated_load;
    assign so_en   = ctrl_q.syncout_zero;
    assign reload  = ctrl_eff.phase_en && (sync_in || sw_sync);

    ptb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .reload(reload), .phase(phase_eff), .dir_in(dir_eff),
        .prd(prd_act), .cnt(count), .up(count_up)
    );

    ptb_events #(.CNT_W(CNT_W)) u_ev (
        .cnt(count), .up(count_up), .prd(prd_act), .cmp(cmp_act),
        .ev_zero(ev_zero), .ev_prd(ev_prd), .ev_up(ev_up), .ev_dn(ev_dn)
    );

    assign ev_cmpa_up = ev_up[0];
    assign ev_cmpa_dn = ev_dn[0];
    assign ev_cmpb_up = ev_up[1];
    assign ev_cmpb_dn = ev_dn[1];
    assign sync_out   = (so_en && ev_zero) || sw_sync;

endmodule

// File: rtl/ptb_timebase_chk.sv
module ptb_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic             count_up,
    input logic             reload,
    input logic [CNT_W-1:0] phase_eff,
    input logic             dir_eff,
    input logic [CNT_W-1:0] prd_act,
    input logic             ld_go,
    input logic             armed,
    input logic             gated,
    input logic             so_en,
    input logic             ev_zero,
    input logic             sync_out
);
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!reload && prd_act != '0 && count <= prd_act) |=>
        (count == $past(count) + CNT_W'(1)) || (count == $past(count) - CNT_W'(1)));

    p_turn_down_r2: assert property (@(posedge clk) disable iff (rst)
        (!reload && count_up && prd_act != '0 && count >= prd_act) |=> !count_up);

    p_turn_up_r2: assert property (@(posedge clk) disable iff (rst)
        (!reload && !count_up && count == '0) |=> count_up);

    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        reload |=> (count == $past(phase_eff)) && (count_up == $past(dir_eff)));

    p_shadow_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ld_go |=> $stable(prd_act));

    p_no_unarmed_load_r6: assert property (@(posedge clk) disable iff (rst)
        (gated && !armed) |-> !ld_go);

    p_arm_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (ld_go && gated) |=> !armed);

    p_zero_sync_r7: assert property (@(posedge clk) disable iff (rst)
        (ev_zero && so_en) |-> sync_out);

endmodule

bind ptb_timebase ptb_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .count(count), .count_up(count_up), .reload(reload),
    .phase_eff(phase_eff), .dir_eff(dir_eff), .prd_act(prd_act), .ld_go(ld_go),
    .armed(armed), .gated(gated), .so_en(so_en), .ev_zero(ev_zero), .sync_out(sync_out)
);

// File: tb/ptb_timebase_tb.sv
`timescale 1ns/1ps
module ptb_timebase_tb;

    localparam int W = 16;
    localparam logic [2:0] A_CTRL = 3'd0, A_PHASE = 3'd1, A_PRD = 3'd2, A_CMD = 3'd5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic sync_in = 1'b0;
    logic sync_out, count_up, ev_zero, ev_prd;
    logic ev_cmpa_up, ev_cmpa_dn, ev_cmpb_up, ev_cmpb_dn;
    logic [W-1:0] count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ptb_timebase u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sync_in(sync_in), .sync_out(sync_out), .count(count), .count_up(count_up),
        .ev_zero(ev_zero), .ev_prd(ev_prd), .ev_cmpa_up(ev_cmpa_up),
        .ev_cmpa_dn(ev_cmpa_dn), .ev_cmpb_up(ev_cmpb_up), .ev_cmpb_dn(ev_cmpb_dn)
    );

    typedef struct packed {
        logic       wr;
        logic [2:0] addr;
        logic [15:0] data;
        logic       sync;
        logic [7:0] wait_n;
        logic [15:0] exp_cnt;
        logic       exp_up;
        logic [3:0] req;
    } vec_t;

    // Walked from reset with period 10; comments give the cycle index after release
    localparam vec_t VECS [11] = '{
        '{1'b0, 3'd0, 16'd0, 1'b0, 8'd4,  16'd5, 1'b1, 4'd2},  // t5   R2
        '{1'b1, 3'd0, 16'd3, 1'b0, 8'd0,  16'd6, 1'b1, 4'd2},  // t6   ctrl only
        '{1'b1, 3'd1, 16'd3, 1'b1, 8'd0,  16'd3, 1'b1, 4'd4},  // t7   R4 phase bypass
        '{1'b0, 3'd0, 16'd0, 1'b0, 8'd2,  16'd6, 1'b1, 4'd3},  // t10  R3
        '{1'b1, 3'd0, 16'd1, 1'b1, 8'd0,  16'd3, 1'b0, 4'd4},  // t11  R4 dir bypass
        '{1'b0, 3'd0, 16'd0, 1'b0, 8'd2,  16'd0, 1'b0, 4'd2},  // t14
        '{1'b0, 3'd0, 16'd0, 1'b0, 8'd0,  16'd1, 1'b1, 4'd2},  // t15  turn up
        '{1'b1, 3'd0, 16'd0, 1'b1, 8'd0,  16'd2, 1'b1, 4'd3},  // t16  sync ignored
        '{1'b1, 3'd2, 16'd4, 1'b0, 8'd0,  16'd3, 1'b1, 4'd5},  // t17  shadow write
        '{1'b0, 3'd0, 16'd0, 1'b0, 8'd8,  16'd8, 1'b0, 4'd5},  // t26  old period held
        '{1'b0, 3'd0, 16'd0, 1'b0, 8'd12, 16'd3, 1'b0, 4'd5}   // t39  new period 4
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_sync();
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0; sync_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #0.5;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int e_zero, e_prd, e_au, e_ad, e_bu, e_bd;

        // R1 reset state
        do_reset();
        chk("R1 count", int'(count), 0);
        chk("R1 dir", int'(count_up), 1);
        chk("R1 zero strobe", int'(ev_zero), 1);
        chk("R1 prd strobe", int'(ev_prd), 0);
        chk("R1 sync_out", int'(sync_out), 0);

        // Vector table walk
        for (int i = 0; i < 11; i++) begin
            wr_en = VECS[i].wr; wr_addr = VECS[i].addr;
            wr_data = VECS[i].data; sync_in = VECS[i].sync;
            @(negedge clk);
            wr_en = 1'b0; sync_in = 1'b0;
            tick(int'(VECS[i].wait_n));
            chk($sformatf("R%0d vec%0d count", VECS[i].req, i), int'(count), int'(VECS[i].exp_cnt));
            chk($sformatf("R%0d vec%0d dir", VECS[i].req, i), int'(count_up), int'(VECS[i].exp_up));
        end

        // R9 strobe positions across one triangle: P=10, A=4, B=7
        do_reset();
        e_zero = 0; e_prd = 0; e_au = 0; e_ad = 0; e_bu = 0; e_bd = 0;
        for (int t = 1; t <= 20; t++) begin
            @(negedge clk);
            if (ev_zero    != (t == 20)) e_zero++;
            if (ev_prd     != (t == 10)) e_prd++;
            if (ev_cmpa_up != (t == 4))  e_au++;
            if (ev_cmpa_dn != (t == 16)) e_ad++;
            if (ev_cmpb_up != (t == 7))  e_bu++;
            if (ev_cmpb_dn != (t == 13)) e_bd++;
        end
        chk("R9 zero strobe errors", e_zero, 0);
        chk("R9 period strobe errors", e_prd, 0);
        chk("R9 cmpa up errors", e_au, 0);
        chk("R9 cmpa down errors", e_ad, 0);
        chk("R9 cmpb up errors", e_bu, 0);
        chk("R9 cmpb down errors", e_bd, 0);

        // R6 gated one-shot load (control bit 3)
        do_reset();
        wr(A_CTRL, 16'h0008);              // t1
        wr(A_PRD, 16'd6);                  // t2
        tick(28);                          // t30: zero at t20 did not load
        chk("R6 unarmed count", int'(count), 10);
        wr(A_CMD, 16'h0001);               // t31 arm
        tick(16);                          // t47: loaded at t40 zero, turned at 6
        chk("R6 armed load count", int'(count), 5);
        tick(11);                          // t58: arm cleared, period still 6
        chk("R6 arm self-clear count", int'(count), 6);

        // R7/R8 software sync and zero sync output
        do_reset();
        wr(A_CTRL, 16'h0005);              // t1 phase_en, sync-out at zero, dir down
        wr(A_PHASE, 16'd9);                // t2
        wr(A_CMD, 16'h0002);               // t3
        chk("R7 software sync pulse", int'(sync_out), 1);
        tick(1);                           // t4
        chk("R8 software sync reload", int'(count), 9);
        chk("R7 single pulse", int'(sync_out), 0);
        tick(9);                           // t13 count 0
        chk("R7 zero sync_out", int'(sync_out), 1);

        // R10 sync coinciding with a zero-cycle shadow load
        do_reset();
        wr(A_CTRL, 16'h0003);              // t1
        wr(A_PHASE, 16'd2);                // t2
        wr(A_PRD, 16'd5);                  // t3
        tick(17);                          // t20 zero cycle
        chk("R10 at zero", int'(ev_zero), 1);
        pulse_sync();                      // t21
        chk("R10 phase taken", int'(count), 2);
        tick(4);                           // t25: turned at new period 5
        chk("R10 load completed", int'(count), 4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule